// File: doc/BRIEF.md
# Half-Precision Leading-One Normalizer

This block turns a loosely scaled intermediate value into a packed 16-bit floating-point word. The input is a two's-complement mantissa of `MAN_W` bits and a signed exponent of `EXP_W` bits. The input exponent is the biased exponent the value would have if its leading 1 already sat at bit position 10 of the magnitude. A sum kept in unnormalized form, where renormalization was put off until the value leaves the datapath, can be passed in directly.

The block records the sign and takes the magnitude. A priority encoder finds the highest set bit of the magnitude. The magnitude is then shifted right or left so that this bit becomes the hidden bit, and the exponent moves by the same number of places. The block rounds to nearest-even from guard and sticky bits, corrects the exponent if rounding carries out, and handles zero, underflow and overflow.

The stream interface is valid/ready on both sides, with a two-stage pipeline that moves as one unit:
- An input is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or `out_ready` is high.
- While `out_valid` is high and `out_ready` is low, the whole pipeline holds and the output word does not change.

Top module: `hp_normalizer`

## Requirements
- R1: For an in-range result, `out_data[9:0]` holds the bits directly below the leading 1 of the magnitude, and the hidden bit is dropped. The packing is sign at bit 15, biased exponent at bits 14:10 and fraction at bits 9:0 (exp 15, mantissa 1024 gives 16'h3C00).
- R2: A leading 1 below bit 10 is shifted left, and the exponent is reduced by the shift distance (exp 25, mantissa 3 gives 16'h4200).
- R3: A leading 1 above bit 10 is shifted right, and the exponent is increased by the shift distance (exp 15, mantissa 2048 gives 16'h4000).
- R4: A negative mantissa sets bit 15, and its magnitude is normalized. The most negative mantissa is handled (exp 15, mantissa -2^23 gives 16'hF000).
- R5: Bits shifted out on the right are rounded to nearest, with ties going to an even fraction.
- R6: When rounding carries out of the 11-bit significand, the exponent is raised by one and the fraction becomes zero.
- R7: A zero mantissa yields 16'h0000 for any exponent.
- R8: A final biased exponent below 1 yields a zero word that keeps the sign bit. No output ever has exponent field 0 with a nonzero fraction.
- R9: A final biased exponent above 30 yields exponent 30 with all-ones fraction and the sign kept. The exponent field is never 31.
- R10: After reset, `out_valid` is low and `in_ready` is high. An input accepted on one edge appears at the output with `out_valid` high after the next edge.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, `in_ready` is low, and no input is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_exp | input | EXP_W | Signed exponent, referenced to the leading 1 at bit 10 |
| in_man | input | MAN_W | Two's-complement mantissa |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | 16 | Packed half-precision result |

## Verification
The assertions check on every cycle that:
- the output word holds under back-pressure;
- the exponent field never reaches the all-ones code;
- no subnormal pattern appears;
- the first pipeline stage's encoder result points exactly at the highest set bit.

The directed scenarios show behaviour that needs known inputs. These are the exact packed values after left and right shifts, the even tie-break against sticky-driven round-up, the carry that bumps the exponent, signed flush and saturation at the range limits, and the two-edge timing.

// File: rtl/hp_norm_pkg.sv
package hp_norm_pkg;
  localparam int FRAC_BITS = 10;
  localparam int EXPO_BITS = 5;
  localparam int OUT_W     = 1 + EXPO_BITS + FRAC_BITS;
  localparam int MAX_EXP   = (1 << EXPO_BITS) - 2;

  function automatic logic [OUT_W-1:0] sat_word(input logic sgn);
    return {sgn, EXPO_BITS'(MAX_EXP), {FRAC_BITS{1'b1}}};
  endfunction
endpackage

// File: rtl/hp_lead_one.sv
module hp_lead_one #(
  parameter int W  = 24,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end
endmodule

// File: rtl/hp_shift_round.sv
module hp_shift_round
  import hp_norm_pkg::*;
#(
  parameter int MW = 24,
  parameter int EW = 8,
  localparam int PW = $clog2(MW),
  localparam int XW = EW + 2,
  localparam int SW = FRAC_BITS + 1
) (
  input  logic [MW-1:0]  mag,
  input  logic [PW-1:0]  pos,
  input  logic [EW-1:0]  exp_in,
  input  logic           sgn,
  input  logic           zero,
  output logic [OUT_W-1:0] word
);
  logic          right;
  logic [PW-1:0] rsh, lsh;
  logic [SW-1:0] kept;
  logic          guard, sticky, inc;
  logic [SW:0]   sum;
  logic [XW-1:0] e_pre, e_fin;
  logic [FRAC_BITS-1:0] frac;
  int unsigned   st_sh;

  always_comb begin
    right  = pos > PW'(FRAC_BITS);
    rsh    = pos - PW'(FRAC_BITS);
    lsh    = PW'(FRAC_BITS) - pos;
    kept   = right ? SW'(mag >> rsh) : SW'(mag << lsh);
    guard  = right && ((mag >> (rsh - PW'(1))) & MW'(1)) != '0;
    st_sh  = MW + 1 - int'(rsh);
    sticky = right && ((mag << st_sh) != '0);
    inc    = guard && (sticky || kept[0]);
    sum    = {1'b0, kept} + (SW+1)'(inc);
    frac   = sum[SW] ? sum[SW-1:1] : sum[FRAC_BITS-1:0];
    e_pre  = {{(XW-EW){exp_in[EW-1]}}, exp_in} + XW'(pos) - XW'(FRAC_BITS);
    e_fin  = e_pre + XW'(sum[SW]);
    if (zero)
      word = '0;
    else if (e_fin[XW-1] || e_fin == '0)
      word = {sgn, {(OUT_W-1){1'b0}}};
    else if (e_fin > XW'(MAX_EXP))
      word = sat_word(sgn);
    else
      word = {sgn, e_fin[EXPO_BITS-1:0], frac};
  end
endmodule

// File: rtl/hp_normalizer.sv
module hp_normalizer
  import hp_norm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [MAN_W-1:0] in_man,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int PW = $clog2(MAN_W);

  logic             adv;
  logic             neg;
  logic [MAN_W-1:0] mag;
  logic [PW-1:0]    pos;

  logic             s1_valid, s1_sign, s1_zero;
  logic [MAN_W-1:0] s1_mag;
  logic [PW-1:0]    s1_pos;
  logic [EXP_W-1:0] s1_exp;
  logic [OUT_W-1:0] packed_w;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign neg      = in_man[MAN_W-1];
  assign mag      = neg ? (~in_man + MAN_W'(1)) : in_man;

  hp_lead_one #(.W(MAN_W)) u_lead (.vec(mag), .pos(pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b1;
      s1_mag   <= '0;
      s1_pos   <= '0;
      s1_exp   <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_sign  <= neg;
      s1_zero  <= (in_man == '0);
      s1_mag   <= mag;
      s1_pos   <= pos;
      s1_exp   <= in_exp;
    end
  end

  hp_shift_round #(.MW(MAN_W), .EW(EXP_W)) u_round (
    .mag(s1_mag), .pos(s1_pos), .exp_in(s1_exp),
    .sgn(s1_sign), .zero(s1_zero), .word(packed_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_data  <= packed_w;
    end
  end

  // R1 R2 R3: encoder result marks exactly the highest set bit
  lead_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !s1_zero |-> (s1_mag >> s1_pos) == MAN_W'(1));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  no_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[OUT_W-2:FRAC_BITS] != {EXPO_BITS{1'b1}});

  // R8
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[OUT_W-2:FRAC_BITS] == '0 |-> out_data[FRAC_BITS-1:0] == '0);
endmodule

// File: tb/hp_normalizer_test.sv
`timescale 1ns/1ps
module hp_normalizer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_exp = '0;
  logic [23:0] in_man = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hp_normalizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_exp(in_exp), .in_man(in_man), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one transfer with a free consumer; R10 timing checked on each
  task automatic run_one(input string tag, input int e, input int m, input logic [15:0] exp_w);
    @(negedge clk);
    in_valid = 1'b1; in_exp = 8'(e); in_man = 24'(m); out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 not early", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R10 valid", 32'(out_valid), 32'd1);
    chk(tag, 32'(out_data), 32'(exp_w));
  endtask

  task automatic t_reset();
    chk("R10 reset valid", 32'(out_valid), 32'd0);
    chk("R10 reset ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_shifts();
    run_one("R1 one", 15, 1024, 16'h3C00);
    run_one("R1 frac", 15, 1024 + 5, 16'h3C05);
    run_one("R2 left", 25, 3, 16'h4200);
    run_one("R2 left one", 25, 1, 16'h3C00);
    run_one("R3 right", 15, 2048, 16'h4000);
  endtask

  task automatic t_sign();
    run_one("R4 neg", 15, -1024, 16'hBC00);
    run_one("R4 most neg", 15, -(1 << 23), 16'hF000);
  endtask

  task automatic t_round();
    run_one("R5 tie even", 15, 'h801, 16'h4000);
    run_one("R5 tie odd", 15, 'h803, 16'h4002);
    run_one("R5 below half", 15, 'h1001, 16'h4400);
    run_one("R5 sticky", 15, 'h1003, 16'h4401);
    run_one("R6 carry", 15, 'hFFF, 16'h4400);
  endtask

  task automatic t_limits();
    run_one("R7 zero", 20, 0, 16'h0000);
    run_one("R7 zero neg exp", -50, 0, 16'h0000);
    run_one("R8 flush", 0, 1024, 16'h0000);
    run_one("R8 flush neg", -5, -1024, 16'h8000);
    run_one("R8 edge one", 1, 1024, 16'h0400);
    run_one("R9 top ok", 30, 1024, 16'h7800);
    run_one("R9 sat", 31, 1024, 16'h7BFF);
    run_one("R9 sat neg", 100, -2048, 16'hFBFF);
    run_one("R9 carry sat", 29, 'hFFF, 16'h7BFF);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_exp = 8'd15; in_man = 24'd2048;
    @(negedge clk);
    in_man = 24'd1024;
    @(negedge clk);
    chk("R11 valid", 32'(out_valid), 32'd1);
    chk("R11 data", 32'(out_data), 32'h4000);
    chk("R11 ready low", 32'(in_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 hold", 32'(out_data), 32'h4000);
    in_exp = 8'd16; in_man = 24'd1024;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 second", 32'(out_data), 32'h3C00);
    @(negedge clk);
    chk("R11 third", 32'(out_data), 32'h4000);
    @(negedge clk);
    chk("R11 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_shifts();
    t_sign();
    t_round();
    t_limits();
    t_stall();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule